// File: doc/BRIEF.md
# Multi-precision SIMD multiply-accumulate unit

This unit is the multiply-accumulate engine of one compute block in a DSP datapath. Every cycle it can accept two 64-bit operand words together with a mode select and an operation code. The same private accumulator bank serves three configurations. In quad mode there are four independent signed 16-bit lanes, each with a 40-bit accumulator, so four MACs complete per cycle. In single mode one signed 32x32 product goes into an 80-bit accumulator, built from two of the 40-bit registers. In complex mode one 16-bit real/imaginary pair is multiplied and accumulated into a real and an imaginary 40-bit accumulator.

The unit has two pipeline stages. The first registers the raw products. The second combines them, updates the accumulators and, on a read, registers a saturated copy of the accumulators. After the mode changes the accumulator contents are undefined, so software clears them before it uses a new mode.

Top module: `simd_mac`

## Requirements
- R1: After a synchronous active-low reset, `out_valid_o` is 0 and every accumulator reads back as zero.
- R2: Quad mode (mode 0): lane i uses operand bits [16i+15:16i] as signed 16-bit values. A MAC (op 2) adds the 32-bit product to the lane's own 40-bit accumulator, which keeps values beyond 32 bits. The lanes are independent.
- R3: Single mode (mode 1): operand bits [31:0] are signed 32-bit values and bits [63:32] are ignored. A MAC adds the 64-bit product to an 80-bit accumulator, and a read places the result on `result_o[63:0]` with bits [127:64] zero.
- R4: Complex mode (mode 2): lane 0 is the real part and lane 1 the imaginary part, and lanes 2 and 3 are ignored. A MAC adds ar*br-ai*bi to the real accumulator and ar*bi+ai*br to the imaginary accumulator. A read gives the real part on [31:0], the imaginary part on [63:32], and zero on [127:64] and on `ovf_o[3:2]`.
- R5: Clear (op 0) zeroes the accumulators of the selected mode.
- R6: Multiply-load (op 1) replaces the accumulator contents with the product.
- R7: Multiply-subtract (op 3) subtracts the product from the accumulator.
- R8: A read (op 4) accepted in cycle t raises `out_valid_o` for one cycle after the second rising edge. Its value includes every operation accepted before it, including one issued in the cycle just before it. `out_valid_o` is high for reads only, and `result_o` and `ovf_o` hold their values between reads.
- R9: In quad and complex mode a read saturates each 40-bit accumulator to signed 32 bits (0x7FFFFFFF or 0x80000000) and sets `ovf_o[i]` for each lane that overflowed. The accumulator itself is left unchanged.
- R10: In single mode a read saturates the 80-bit accumulator to signed 64 bits and sets `ovf_o[0]` on overflow, with `ovf_o[3:1]` zero.
- R11: While `in_valid` is low, the inputs have no effect on the accumulators or on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| mode_i | input | 2 | 0 quad, 1 single 32-bit, 2 complex |
| op_i | input | 3 | 0 clear, 1 multiply-load, 2 MAC, 3 multiply-subtract, 4 read |
| opa_i | input | 64 | First operand word |
| opb_i | input | 64 | Second operand word |
| out_valid_o | output | 1 | Read result present |
| result_o | output | 128 | Saturated accumulator values |
| ovf_o | output | 4 | Per-lane saturation flags |

## Verification
The bench pushes quad accumulators past the 32-bit read range in both directions. A unit that wrapped instead of saturating, or that kept only 32 bits of accumulator, would return the wrong value after the later subtractions bring the total back into range. The bench drives the 80-bit path to exactly 2^63 and below -2^63, which catches a bad overflow test at the boundary. It puts non-zero data in the ignored operand lanes, which catches operands routed across lanes in the single and complex modes. A read issued in the cycle directly after a MAC shows whether the read takes the accumulator value before the update has landed. Inputs held with `in_valid` low show whether the gating of operations leaks.

// File: rtl/simd_mac_pkg.sv
// Package: shared encodings for the SIMD multiply-accumulate unit.
// Assumes the mode and operation fields are decoded by the issuing stage.
package simd_mac_pkg;

    typedef enum logic [1:0] {
        MODE_QUAD = 2'd0,
        MODE_WIDE = 2'd1,
        MODE_CPLX = 2'd2
    } mac_mode_e;

    typedef enum logic [2:0] {
        OP_CLR = 3'd0,
        OP_MLD = 3'd1,
        OP_MAC = 3'd2,
        OP_MSU = 3'd3,
        OP_RD  = 3'd4
    } mac_op_e;

endpackage

// File: rtl/simd_mac_mul.sv
// Stage 1: selects multiplier operands per mode and registers the raw products.
// In complex mode lanes 2 and 3 form the cross terms ar*bi and ai*br.
// Assumes LANES >= 4 so that a complex pair has four multipliers available.
module simd_mac_mul
    import simd_mac_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int LANE_W = 16,
    parameter int WIDE_W = 32,
    localparam int DATA_W  = LANES * LANE_W,
    localparam int PROD_W  = 2 * LANE_W,
    localparam int WPROD_W = 2 * WIDE_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    input  logic [1:0]                    mode_i,
    input  logic [2:0]                    op_i,
    input  logic [DATA_W-1:0]             opa_i,
    input  logic [DATA_W-1:0]             opb_i,
    output logic                          s1_valid_o,
    output logic [1:0]                    s1_mode_o,
    output logic [2:0]                    s1_op_o,
    output logic [LANES-1:0][PROD_W-1:0]  lane_prod_o,
    output logic [WPROD_W-1:0]            wide_prod_o
);

    // Control travelling with the operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid_o <= 1'b0;
            s1_mode_o  <= 2'd0;
            s1_op_o    <= 3'd0;
        end else begin
            s1_valid_o <= in_valid;
            if (in_valid) begin
                s1_mode_o <= mode_i;
                s1_op_o   <= op_i;
            end
        end
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam int CA = (i == 3) ? 1 : 0;
        localparam int CB = (i == 2) ? 1 : 0;
        logic signed [LANE_W-1:0] mul_a, mul_b;
        logic signed [PROD_W-1:0] prod;

        // Operand routing: straight lanes, or cross terms for complex lanes 2/3.
        always_comb begin
            mul_a = opa_i[i*LANE_W +: LANE_W];
            mul_b = opb_i[i*LANE_W +: LANE_W];
            if ((i == 2 || i == 3) && mode_i == MODE_CPLX) begin
                mul_a = opa_i[CA*LANE_W +: LANE_W];
                mul_b = opb_i[CB*LANE_W +: LANE_W];
            end
        end

        assign prod = PROD_W'(mul_a) * PROD_W'(mul_b);

        // Product register for this lane.
        always_ff @(posedge clk) begin
            if (!rst_n)
                lane_prod_o[i] <= '0;
            else if (in_valid)
                lane_prod_o[i] <= prod;
        end
    end

    logic signed [WIDE_W-1:0]  wide_a, wide_b;
    logic signed [WPROD_W-1:0] wide_prod;

    assign wide_a    = opa_i[WIDE_W-1:0];
    assign wide_b    = opb_i[WIDE_W-1:0];
    assign wide_prod = WPROD_W'(wide_a) * WPROD_W'(wide_b);

    // Product register for the single wide lane.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wide_prod_o <= '0;
        else if (in_valid)
            wide_prod_o <= wide_prod;
    end

endmodule

// File: rtl/simd_mac_acc.sv
// Stage 2: forms the addend terms, updates the accumulator bank and
// registers saturated read-out. The wide accumulator overlays lanes 0 and 1.
// Assumes WACC_W == 2*ACC_W and WRES_W <= LANES*RES_W.
module simd_mac_acc
    import simd_mac_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int LANE_W = 16,
    parameter int ACC_W  = 40,
    parameter int RES_W  = 32,
    parameter int WIDE_W = 32,
    parameter int WRES_W = 64,
    localparam int PROD_W  = 2 * LANE_W,
    localparam int WPROD_W = 2 * WIDE_W,
    localparam int WACC_W  = 2 * ACC_W,
    localparam int OUT_W   = LANES * RES_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          s1_valid_i,
    input  logic [1:0]                    s1_mode_i,
    input  logic [2:0]                    s1_op_i,
    input  logic [LANES-1:0][PROD_W-1:0]  lane_prod_i,
    input  logic [WPROD_W-1:0]            wide_prod_i,
    output logic                          out_valid_o,
    output logic [OUT_W-1:0]              result_o,
    output logic [LANES-1:0]              ovf_o
);

    localparam logic [RES_W-1:0]  RMAX = {1'b0, {(RES_W-1){1'b1}}};
    localparam logic [RES_W-1:0]  RMIN = {1'b1, {(RES_W-1){1'b0}}};
    localparam logic [WRES_W-1:0] WMAX = {1'b0, {(WRES_W-1){1'b1}}};
    localparam logic [WRES_W-1:0] WMIN = {1'b1, {(WRES_W-1){1'b0}}};

    function automatic logic signed [ACC_W-1:0] lane_upd(
        input logic signed [ACC_W-1:0] acc, input logic signed [ACC_W-1:0] t, input logic [2:0] o);
        case (o)
            OP_CLR:  lane_upd = '0;
            OP_MLD:  lane_upd = t;
            OP_MAC:  lane_upd = acc + t;
            OP_MSU:  lane_upd = acc - t;
            default: lane_upd = acc;
        endcase
    endfunction

    function automatic logic signed [WACC_W-1:0] wide_upd(
        input logic signed [WACC_W-1:0] acc, input logic signed [WACC_W-1:0] t, input logic [2:0] o);
        case (o)
            OP_CLR:  wide_upd = '0;
            OP_MLD:  wide_upd = t;
            OP_MAC:  wide_upd = acc + t;
            OP_MSU:  wide_upd = acc - t;
            default: wide_upd = acc;
        endcase
    endfunction

    logic signed [ACC_W-1:0]  ext   [LANES];
    logic signed [ACC_W-1:0]  term  [LANES];
    logic signed [ACC_W-1:0]  acc_q [LANES];
    logic signed [ACC_W-1:0]  acc_d [LANES];
    logic signed [WACC_W-1:0] wide_cur, wide_d, wide_term;
    logic [RES_W-1:0]         lane_sat [LANES];
    logic [LANES-1:0]         lane_ovf;
    logic [WRES_W-1:0]        wide_sat;
    logic                     wide_ovf;
    logic [OUT_W-1:0]         rd_res;
    logic [LANES-1:0]         rd_ovf;

    for (genvar i = 0; i < LANES; i++) begin : g_ext
        assign ext[i] = ACC_W'(signed'(lane_prod_i[i]));
    end

    assign wide_term = WACC_W'(signed'(wide_prod_i));
    assign wide_cur  = {acc_q[1], acc_q[0]};

    // Addend per lane: plain products, or combined real/imaginary terms.
    always_comb begin
        for (int i = 0; i < LANES; i++) term[i] = ext[i];
        if (s1_mode_i == MODE_CPLX) begin
            for (int i = 2; i < LANES; i++) term[i] = '0;
            term[0] = ext[0] - ext[1];
            term[1] = ext[2] + ext[3];
        end
    end

    // Next accumulator state for the mode that the operation selects.
    always_comb begin
        for (int i = 0; i < LANES; i++) acc_d[i] = acc_q[i];
        wide_d = wide_cur;
        if (s1_valid_i) begin
            case (s1_mode_i)
                MODE_QUAD: for (int i = 0; i < LANES; i++) acc_d[i] = lane_upd(acc_q[i], term[i], s1_op_i);
                MODE_CPLX: for (int i = 0; i < 2; i++) acc_d[i] = lane_upd(acc_q[i], term[i], s1_op_i);
                MODE_WIDE: begin
                    wide_d   = wide_upd(wide_cur, wide_term, s1_op_i);
                    acc_d[0] = wide_d[ACC_W-1:0];
                    acc_d[1] = wide_d[WACC_W-1:ACC_W];
                end
                default: ;
            endcase
        end
    end

    // Accumulator bank register.
    always_ff @(posedge clk) begin
        for (int i = 0; i < LANES; i++) begin
            if (!rst_n) acc_q[i] <= '0;
            else        acc_q[i] <= acc_d[i];
        end
    end

    for (genvar i = 0; i < LANES; i++) begin : g_sat
        logic [ACC_W-RES_W:0] hi;
        assign hi          = acc_q[i][ACC_W-1:RES_W-1];
        assign lane_ovf[i] = !((&hi) || !(|hi));
        assign lane_sat[i] = lane_ovf[i] ? (acc_q[i][ACC_W-1] ? RMIN : RMAX) : acc_q[i][RES_W-1:0];
    end

    logic [WACC_W-WRES_W:0] whi;
    assign whi      = wide_cur[WACC_W-1:WRES_W-1];
    assign wide_ovf = !((&whi) || !(|whi));
    assign wide_sat = wide_ovf ? (wide_cur[WACC_W-1] ? WMIN : WMAX) : wide_cur[WRES_W-1:0];

    // Read-out word for the mode of the read operation.
    always_comb begin
        rd_res = '0;
        rd_ovf = '0;
        case (s1_mode_i)
            MODE_QUAD: for (int i = 0; i < LANES; i++) begin
                rd_res[i*RES_W +: RES_W] = lane_sat[i];
                rd_ovf[i] = lane_ovf[i];
            end
            MODE_CPLX: for (int i = 0; i < 2; i++) begin
                rd_res[i*RES_W +: RES_W] = lane_sat[i];
                rd_ovf[i] = lane_ovf[i];
            end
            MODE_WIDE: begin
                rd_res[WRES_W-1:0] = wide_sat;
                rd_ovf[0] = wide_ovf;
            end
            default: ;
        endcase
    end

    // Output register: updated only by a read, held otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid_o <= 1'b0;
            result_o    <= '0;
            ovf_o       <= '0;
        end else begin
            out_valid_o <= s1_valid_i && (s1_op_i == OP_RD);
            if (s1_valid_i && (s1_op_i == OP_RD)) begin
                result_o <= rd_res;
                ovf_o    <= rd_ovf;
            end
        end
    end

endmodule

// File: rtl/simd_mac.sv
// Top: two-stage multi-precision SIMD multiply-accumulate unit with a private
// accumulator bank. Assumes the accumulators are cleared after a mode change.
module simd_mac
    import simd_mac_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int LANE_W = 16,
    parameter int ACC_W  = 40,
    parameter int RES_W  = 32,
    parameter int WIDE_W = 32,
    parameter int WRES_W = 64,
    localparam int DATA_W  = LANES * LANE_W,
    localparam int OUT_W   = LANES * RES_W,
    localparam int PROD_W  = 2 * LANE_W,
    localparam int WPROD_W = 2 * WIDE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        mode_i,
    input  logic [2:0]        op_i,
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    output logic              out_valid_o,
    output logic [OUT_W-1:0]  result_o,
    output logic [LANES-1:0]  ovf_o
);

    logic                         s1_valid;
    logic [1:0]                   s1_mode;
    logic [2:0]                   s1_op;
    logic [LANES-1:0][PROD_W-1:0] lane_prod;
    logic [WPROD_W-1:0]           wide_prod;

    simd_mac_mul #(.LANES(LANES), .LANE_W(LANE_W), .WIDE_W(WIDE_W)) i_mul (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode_i(mode_i), .op_i(op_i),
        .opa_i(opa_i), .opb_i(opb_i), .s1_valid_o(s1_valid), .s1_mode_o(s1_mode),
        .s1_op_o(s1_op), .lane_prod_o(lane_prod), .wide_prod_o(wide_prod)
    );

    simd_mac_acc #(.LANES(LANES), .LANE_W(LANE_W), .ACC_W(ACC_W), .RES_W(RES_W),
                   .WIDE_W(WIDE_W), .WRES_W(WRES_W)) i_acc (
        .clk(clk), .rst_n(rst_n), .s1_valid_i(s1_valid), .s1_mode_i(s1_mode),
        .s1_op_i(s1_op), .lane_prod_i(lane_prod), .wide_prod_i(wide_prod),
        .out_valid_o(out_valid_o), .result_o(result_o), .ovf_o(ovf_o)
    );

endmodule

// File: rtl/simd_mac_chk.sv
// Checker: port-level timing and read-out format properties of simd_mac.
module simd_mac_chk
    import simd_mac_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int RES_W  = 32,
    parameter int WRES_W = 64,
    localparam int OUT_W = LANES * RES_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [1:0]       mode_i,
    input logic [2:0]       op_i,
    input logic             out_valid_o,
    input logic [OUT_W-1:0] result_o,
    input logic [LANES-1:0] ovf_o
);

    localparam logic [RES_W-1:0]  RMAX = {1'b0, {(RES_W-1){1'b1}}};
    localparam logic [RES_W-1:0]  RMIN = {1'b1, {(RES_W-1){1'b0}}};
    localparam logic [WRES_W-1:0] WMAX = {1'b0, {(WRES_W-1){1'b1}}};
    localparam logic [WRES_W-1:0] WMIN = {1'b1, {(WRES_W-1){1'b0}}};

    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !out_valid_o);

    a_r8_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_i == OP_RD) |=> ##1 out_valid_o);

    a_r8_only_reads: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> $past(in_valid && op_i == OP_RD, 2));

    a_r8_hold_between_reads: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid_o |-> ($stable(result_o) && $stable(ovf_o)));

    a_r4_cplx_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && $past(mode_i, 2) == MODE_CPLX) |->
        (result_o[OUT_W-1:2*RES_W] == '0 && ovf_o[LANES-1:2] == '0));

    a_r10_wide_format: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && $past(mode_i, 2) == MODE_WIDE) |->
        (result_o[OUT_W-1:WRES_W] == '0 && ovf_o[LANES-1:1] == '0));

    a_r10_wide_sat: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && ovf_o[0] && $past(mode_i, 2) == MODE_WIDE) |->
        (result_o[WRES_W-1:0] == WMAX || result_o[WRES_W-1:0] == WMIN));

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        a_r9_lane_sat: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid_o && ovf_o[g] && $past(mode_i, 2) != MODE_WIDE) |->
            (result_o[g*RES_W +: RES_W] == RMAX || result_o[g*RES_W +: RES_W] == RMIN));
    end

endmodule

bind simd_mac simd_mac_chk #(.LANES(LANES), .RES_W(RES_W), .WRES_W(WRES_W)) i_simd_mac_chk (.*);

// File: tb/test_simd_mac.sv
`timescale 1ns/1ps
module test_simd_mac;
    import simd_mac_pkg::*;

    typedef struct packed {
        logic [1:0]   mode;
        logic [2:0]   op;
        logic [63:0]  a;
        logic [63:0]  b;
        logic [127:0] exp;
        logic [3:0]   eovf;
        logic [3:0]   rq;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        // R5 quad clear
        '{2'd0, 3'd0, 64'h0, 64'h0, 128'h0, 4'h0, 4'd5},
        // R2 lanes: 3*5, -2*7, 100*-2, -1*-1
        '{2'd0, 3'd2, 64'hFFFF_0064_FFFE_0003, 64'hFFFF_FFFE_0007_0005, 128'h0, 4'h0, 4'd2},
        '{2'd0, 3'd2, 64'hFFFF_0064_FFFE_0003, 64'hFFFF_FFFE_0007_0005, 128'h0, 4'h0, 4'd2},
        '{2'd0, 3'd4, 64'h0, 64'h0, 128'h00000002_FFFFFE70_FFFFFFE4_0000001E, 4'h0, 4'd2},
        // R7 subtract a*1 per lane
        '{2'd0, 3'd3, 64'hFFFF_0064_FFFE_0003, 64'h0001_0001_0001_0001, 128'h0, 4'h0, 4'd7},
        '{2'd0, 3'd4, 64'h0, 64'h0, 128'h00000003_FFFFFE0C_FFFFFFE6_0000001B, 4'h0, 4'd7},
        // R6 load 7*7 into lane 0, zero products elsewhere
        '{2'd0, 3'd1, 64'h0000_0000_0000_0007, 64'h0000_0000_0000_0007, 128'h0, 4'h0, 4'd6},
        '{2'd0, 3'd4, 64'h0, 64'h0, 128'h00000000_00000000_00000000_00000031, 4'h0, 4'd6},
        // R3 single: -3 * 100000, upper operand bits are junk
        '{2'd1, 3'd0, 64'h0, 64'h0, 128'h0, 4'h0, 4'd3},
        '{2'd1, 3'd2, 64'hDEAD_BEEF_FFFF_FFFD, 64'h1234_5678_0001_86A0, 128'h0, 4'h0, 4'd3},
        '{2'd1, 3'd4, 64'h0, 64'h0, 128'h00000000_00000000_FFFFFFFF_FFFB6C20, 4'h0, 4'd3},
        // R4 complex: (3+4j)(5-2j) = 23+14j, then minus (1+j)(1+j) = 2j
        '{2'd2, 3'd0, 64'h0, 64'h0, 128'h0, 4'h0, 4'd4},
        '{2'd2, 3'd2, 64'h1111_2222_0004_0003, 64'h3333_4444_FFFE_0005, 128'h0, 4'h0, 4'd4},
        '{2'd2, 3'd3, 64'h0000_0000_0001_0001, 64'h0000_0000_0001_0001, 128'h0, 4'h0, 4'd4},
        '{2'd2, 3'd4, 64'h0, 64'h0, 128'h00000000_00000000_0000000C_00000017, 4'h0, 4'd4}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [1:0]   mode = 2'd0;
    logic [2:0]   op = 3'd0;
    logic [63:0]  opa = '0;
    logic [63:0]  opb = '0;
    logic         out_valid;
    logic [127:0] result;
    logic [3:0]   ovf;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    simd_mac i_simd_mac (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode_i(mode), .op_i(op),
        .opa_i(opa), .opb_i(opb), .out_valid_o(out_valid), .result_o(result), .ovf_o(ovf)
    );

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [1:0] m, input logic [2:0] o, input logic [63:0] a, input logic [63:0] b);
        @(negedge clk);
        in_valid = 1'b1; mode = m; op = o; opa = a; opb = b;
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic read(input logic [1:0] m, input logic [127:0] er, input logic [3:0] eo, input string tag);
        issue(m, OP_RD, '0, '0);
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        chk({tag, " valid"}, {127'd0, out_valid}, 128'd1);
        chk({tag, " result"}, result, er);
        chk({tag, " ovf"}, {124'd0, ovf}, {124'd0, eo});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R1 reset state
        repeat (4) @(negedge clk);
        chk("R1 valid in reset", {127'd0, out_valid}, 128'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 valid after reset", {127'd0, out_valid}, 128'd0);
        read(MODE_QUAD, 128'h0, 4'h0, "R1 zero accumulators");

        // Vector table, operations issued back to back before each read
        for (int k = 0; k < NV; k++) begin
            if (VECS[k].op == OP_RD)
                read(VECS[k].mode, VECS[k].exp, VECS[k].eovf, $sformatf("R%0d vec %0d", VECS[k].rq, k));
            else
                issue(VECS[k].mode, VECS[k].op, VECS[k].a, VECS[k].b);
        end

        // R8 latency and hold
        issue(MODE_QUAD, OP_CLR, '0, '0);
        issue(MODE_QUAD, OP_MLD, 64'h0000_0000_0000_0002, 64'h0000_0000_0000_0003);
        issue(MODE_QUAD, OP_RD, '0, '0);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R8 not yet valid", {127'd0, out_valid}, 128'd0);
        @(negedge clk);
        chk("R8 valid", {127'd0, out_valid}, 128'd1);
        chk("R8 result", result, 128'h6);
        @(negedge clk);
        chk("R8 one-cycle valid", {127'd0, out_valid}, 128'd0);
        chk("R8 result held", result, 128'h6);

        // R11 inputs ignored while in_valid is low
        mode = MODE_QUAD; op = OP_MAC; opa = 64'h0005_0005_0005_0005; opb = 64'h0003_0003_0003_0003;
        repeat (3) @(negedge clk);
        op = OP_RD;
        repeat (3) @(negedge clk);
        chk("R11 no output", {127'd0, out_valid}, 128'd0);
        read(MODE_QUAD, 128'h6, 4'h0, "R11 accumulators untouched");

        // R5 clear, R6 load replaces in complex mode
        issue(MODE_QUAD, OP_CLR, '0, '0);
        read(MODE_QUAD, 128'h0, 4'h0, "R5 quad cleared");
        issue(MODE_CPLX, OP_CLR, '0, '0);
        issue(MODE_CPLX, OP_MAC, 64'h0000_0000_0004_0003, 64'h0000_0000_FFFE_0005);
        issue(MODE_CPLX, OP_MLD, 64'h0000_0000_0000_0002, 64'h0000_0000_0005_0000);
        read(MODE_CPLX, 128'h0000000A_00000000, 4'h0, "R6 complex load");
        issue(MODE_CPLX, OP_CLR, '0, '0);
        read(MODE_CPLX, 128'h0, 4'h0, "R5 complex cleared");

        // R9 quad saturation, accumulators keep the full value
        issue(MODE_QUAD, OP_CLR, '0, '0);
        issue(MODE_QUAD, OP_MLD, 64'h0000_0000_8000_8000, 64'h0000_0000_7FFF_8000);
        issue(MODE_QUAD, OP_MAC, 64'h0000_0000_8000_8000, 64'h0000_0000_7FFF_8000);
        issue(MODE_QUAD, OP_MAC, 64'h0000_0000_8000_8000, 64'h0000_0000_7FFF_8000);
        read(MODE_QUAD, 128'h00000000_00000000_80000000_7FFFFFFF, 4'b0011, "R9 saturate");
        issue(MODE_QUAD, OP_MSU, 64'h0000_0000_8000_8000, 64'h0000_0000_7FFF_8000);
        issue(MODE_QUAD, OP_MSU, 64'h0000_0000_8000_8000, 64'h0000_0000_7FFF_8000);
        read(MODE_QUAD, 128'h00000000_00000000_C0008000_40000000, 4'b0000, "R9 back in range");

        // R10 single-mode saturation at +2^63 and below -2^63
        issue(MODE_WIDE, OP_CLR, '0, '0);
        issue(MODE_WIDE, OP_MLD, 64'h8000_0000, 64'h8000_0000);
        issue(MODE_WIDE, OP_MAC, 64'h8000_0000, 64'h8000_0000);
        read(MODE_WIDE, 128'h7FFFFFFF_FFFFFFFF, 4'b0001, "R10 positive saturate");
        issue(MODE_WIDE, OP_MSU, 64'h8000_0000, 64'h8000_0000);
        read(MODE_WIDE, 128'h40000000_00000000, 4'b0000, "R10 in range");
        issue(MODE_WIDE, OP_MLD, 64'h8000_0000, 64'h7FFF_FFFF);
        issue(MODE_WIDE, OP_MAC, 64'h8000_0000, 64'h7FFF_FFFF);
        issue(MODE_WIDE, OP_MAC, 64'h8000_0000, 64'h7FFF_FFFF);
        read(MODE_WIDE, 128'h80000000_00000000, 4'b0001, "R10 negative saturate");

        idle();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule